// File: doc/BRIEF.md
# Multiplexed ADC slot sequencer with reference chopper

The block paces a multi-channel sampling front end from a slow timebase enable. Each multiplexer cycle holds 2, 3, 4 or 6 slots. For each slot the block selects an input channel and starts a conversion. It counts the conversion length in timebase ticks. When the conversion ends, it writes the raw result into a data RAM at an address given by the slot. When the last slot of a cycle finishes, it sends a single-clock start pulse to the downstream compute engine, and the next cycle begins on the same tick.

Configuration is sampled only when a cycle starts. A settings change made during a running cycle therefore appears in the following cycle. The reference chopper can be held in normal polarity, held inverted, or toggled. In toggling mode the polarity flips only at a cycle start. An alternate-sequence bit makes every odd-numbered cycle use a second slot-to-channel table. The converter and the filter arithmetic are outside the block. The result arrives on an input bus and is sampled at the tick that ends a conversion.

Top module: `adc_slot_seq`

## Requirements
- R1: The slot-count setting selects the slots per cycle: 00 gives 2, 01 gives 3, 10 gives 4 and 11 gives 6. A cycle spans exactly (slots × conversion length) timebase ticks.
- R2: A conversion lasts 2 ticks when the filter-length bit is 0 and 3 ticks when it is 1. `conv_start` pulses for one clock at the start of every slot.
- R3: At the tick that ends a conversion, `ram_we` pulses for one clock. `ram_addr` is RAM_BASE (default 0x10) plus the slot index, and the slot indices run 0, 1, …, slots−1 within every cycle.
- R4: With the filter-length bit at 0, the result is 21 bits wide and bit 21 of `ram_wdata` is written as 0. With the bit at 1, all 22 bits of `adc_data` are written.
- R5: The chop setting 00 holds `chop_inv` at 0, 01 holds it at 1, and 10 or 11 inverts it at every cycle start. It is 0 after reset.
- R6: `chop_inv` changes only in the clock that follows a cycle-start tick, and never in the middle of a cycle.
- R7: `ce_go` pulses for one clock together with the final RAM write of each cycle. The next cycle's `conv_start` is asserted in the same clock.
- R8: A change to the slot count, filter length, chop mode or alternate bit takes effect only from the next cycle start.
- R9: Cycles are numbered from 0 after reset. With the alternate bit latched at 1, an odd-numbered cycle drives `mux_sel` = slot XOR 1. Every other cycle drives `mux_sel` = slot.
- R10: During reset all pulses are 0, and `mux_sel`, `ram_addr`, `ram_wdata` and `chop_inv` are 0. The first cycle starts at the first tick after reset.
- R11: Outputs change only in the clock that follows a clock with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable, one clock wide |
| cfg_slots | input | 2 | Slots-per-cycle code |
| cfg_long | input | 1 | Filter length: 0 = 2 ticks/21 bits, 1 = 3 ticks/22 bits |
| cfg_chop | input | 2 | Chop mode: 00 normal, 01 inverted, 1x toggling |
| cfg_alt | input | 1 | Alternate channel order on odd cycles |
| adc_data | input | 22 | Raw converter result |
| mux_sel | output | 3 | Input channel select |
| conv_start | output | 1 | Conversion start pulse |
| ram_we | output | 1 | Data RAM write strobe |
| ram_addr | output | 8 | Data RAM write address |
| ram_wdata | output | 22 | Data RAM write data |
| chop_inv | output | 1 | Reference chopper polarity, 1 = inverted |
| ce_go | output | 1 | Compute engine start pulse |

## Verification
The last conversion of a cycle ending and the next cycle starting happen on the same tick. In that clock the final RAM write, the compute-engine pulse, the new conversion start, a possible chop flip and the latching of new settings all coincide. The bench provokes this collision by changing settings in mid-cycle and by running with ticks on every clock as well as with gaps between them. A behavioural model judges every clock, and separate counters check the tick span of each cycle and the order of the write addresses.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    CHOP_HOLD_NORM = 2'b00,
    CHOP_HOLD_INV  = 2'b01,
    CHOP_FLIP_A    = 2'b10,
    CHOP_FLIP_B    = 2'b11
  } chop_mode_e;

  // slot-count code to number of slots
  function automatic logic [2:0] slots_of(input logic [1:0] code);
    case (code)
      2'b00:   slots_of = 3'd2;
      2'b01:   slots_of = 3'd3;
      2'b10:   slots_of = 3'd4;
      default: slots_of = 3'd6;
    endcase
  endfunction

  // conversion length in timebase ticks
  function automatic logic [1:0] conv_ticks(input logic long_filt);
    conv_ticks = long_filt ? 2'd3 : 2'd2;
  endfunction

  // polarity applied at a cycle start
  function automatic logic chop_next(input chop_mode_e mode, input logic pol);
    case (mode)
      CHOP_HOLD_NORM: chop_next = 1'b0;
      CHOP_HOLD_INV:  chop_next = 1'b1;
      default:        chop_next = ~pol;
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [1:0]    cfg_slots,
  input  logic          cfg_long,
  input  logic          cfg_alt,
  output logic [SW-1:0] slot,
  output logic          alt_now,
  output logic          long_now,
  output logic          cyc_start_ev,
  output logic          conv_end_ev,
  output logic          conv_start,
  output logic          ce_go
);
  logic          running;
  logic [1:0]    tcnt;
  logic [SW-1:0] nslot_q;
  logic [1:0]    len_q;
  logic          alt_q, par_q;
  logic          last_slot, cyc_end_ev;

  assign last_slot    = (slot == nslot_q - SW'(1));
  assign conv_end_ev  = tick & running & (tcnt == len_q - 2'd1);
  assign cyc_end_ev   = conv_end_ev & last_slot;
  assign cyc_start_ev = tick & (~running | cyc_end_ev);
  assign alt_now      = alt_q & par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; slot <= '0; tcnt <= '0;
      nslot_q <= SW'(2); len_q <= 2'd2; long_now <= 1'b0;
      alt_q <= 1'b0; par_q <= 1'b0;
      conv_start <= 1'b0; ce_go <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      ce_go      <= 1'b0;
      if (cyc_start_ev) begin
        running    <= 1'b1;
        slot       <= '0;
        tcnt       <= '0;
        nslot_q    <= SW'(slots_of(cfg_slots));
        len_q      <= conv_ticks(cfg_long);
        long_now   <= cfg_long;
        alt_q      <= cfg_alt;
        par_q      <= running ? ~par_q : 1'b0;
        conv_start <= 1'b1;
        ce_go      <= cyc_end_ev;
      end else if (conv_end_ev) begin
        slot       <= slot + SW'(1);
        tcnt       <= '0;
        conv_start <= 1'b1;
      end else if (tick && running) begin
        tcnt <= tcnt + 2'd1;
      end
    end
  end

  // R2
  tcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (tcnt < len_q));
  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (slot < nslot_q));
  // R7
  ce_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_go |-> conv_start);
  // R11
  pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(tick));
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start_ev |=> ($stable(nslot_q) && $stable(len_q) && $stable(alt_q)));
endmodule

// File: rtl/adc_seq_chop.sv
module adc_seq_chop
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_ev,
  input  logic [1:0] cfg_chop,
  output logic       chop_inv
);
  always_ff @(posedge clk) begin
    if (!rst_n)        chop_inv <= 1'b0;
    else if (start_ev) chop_inv <= chop_next(chop_mode_e'(cfg_chop), chop_inv);
  end

  // R6
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ev |=> $stable(chop_inv));
endmodule

// File: rtl/adc_seq_wr.sv
module adc_seq_wr #(
  parameter int         DW        = 22,
  parameter int         AW        = 8,
  parameter int         SW        = 3,
  parameter int         MAX_SLOTS = 6,
  parameter logic [7:0] RAM_BASE  = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_end_ev,
  input  logic          long_now,
  input  logic [SW-1:0] slot,
  input  logic [DW-1:0] adc_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  localparam logic [DW-1:0] SHORT_MASK = {1'b0, {(DW-1){1'b1}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
    end else begin
      ram_we <= conv_end_ev;
      if (conv_end_ev) begin
        ram_addr  <= AW'(RAM_BASE) + AW'(slot);
        ram_wdata <= long_now ? adc_data : (adc_data & SHORT_MASK);
      end
    end
  end

  // R3
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ((ram_addr >= AW'(RAM_BASE)) && (ram_addr < AW'(RAM_BASE) + AW'(MAX_SLOTS))));
  // R4
  short_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end_ev && !long_now) |=> (ram_wdata[DW-1] == 1'b0));
endmodule

// File: rtl/adc_seq_map.sv
module adc_seq_map #(
  parameter int SW        = 3,
  parameter int CH_W      = 3,
  parameter int MAX_SLOTS = 6,
  parameter logic [MAX_SLOTS-1:0][CH_W-1:0] ALT_MAP = '0
) (
  input  logic [SW-1:0]   slot,
  input  logic            alt_now,
  output logic [CH_W-1:0] mux_sel
);
  logic [MAX_SLOTS-1:0][CH_W-1:0] plain_map;

  for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_plain
    assign plain_map[i] = CH_W'(i);
  end

  always_comb begin
    mux_sel = '0;
    if (int'(slot) < MAX_SLOTS)
      mux_sel = alt_now ? ALT_MAP[slot] : plain_map[slot];
  end
endmodule

// File: rtl/adc_slot_seq.sv
module adc_slot_seq #(
  parameter int         DW        = 22,
  parameter int         AW        = 8,
  parameter int         CH_W      = 3,
  parameter int         MAX_SLOTS = 6,
  parameter logic [7:0] RAM_BASE  = 8'h10,
  parameter logic [MAX_SLOTS-1:0][CH_W-1:0] ALT_MAP =
    {3'd4, 3'd5, 3'd2, 3'd3, 3'd0, 3'd1}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [1:0]      cfg_slots,
  input  logic            cfg_long,
  input  logic [1:0]      cfg_chop,
  input  logic            cfg_alt,
  input  logic [DW-1:0]   adc_data,
  output logic [CH_W-1:0] mux_sel,
  output logic            conv_start,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            chop_inv,
  output logic            ce_go
);
  localparam int SW = $clog2(MAX_SLOTS);

  logic [SW-1:0] slot;
  logic          alt_now, long_now, cyc_start_ev, conv_end_ev;

  adc_seq_ctrl #(.SW(SW)) u_ctrl (
    .clk, .rst_n, .tick, .cfg_slots, .cfg_long, .cfg_alt,
    .slot, .alt_now, .long_now, .cyc_start_ev, .conv_end_ev,
    .conv_start, .ce_go
  );

  adc_seq_chop u_chop (
    .clk, .rst_n, .start_ev(cyc_start_ev), .cfg_chop, .chop_inv
  );

  adc_seq_wr #(.DW(DW), .AW(AW), .SW(SW), .MAX_SLOTS(MAX_SLOTS), .RAM_BASE(RAM_BASE)) u_wr (
    .clk, .rst_n, .conv_end_ev, .long_now, .slot, .adc_data,
    .ram_we, .ram_addr, .ram_wdata
  );

  adc_seq_map #(.SW(SW), .CH_W(CH_W), .MAX_SLOTS(MAX_SLOTS), .ALT_MAP(ALT_MAP)) u_map (
    .slot, .alt_now, .mux_sel
  );

  // R7
  ce_last_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_go |-> ram_we);
  // R11
  we_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(tick));
endmodule

// File: tb/tb_adc_slot_seq.sv
module tb_adc_slot_seq;
  localparam int BASE = 16;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [1:0]  cfg_slots = 2'b00, cfg_chop = 2'b00;
  logic        cfg_long = 1'b0, cfg_alt = 1'b0;
  logic [21:0] adc_data = '0;
  logic [2:0]  mux_sel;
  logic        conv_start, ram_we, chop_inv, ce_go;
  logic [7:0]  ram_addr;
  logic [21:0] ram_wdata;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_slot_seq dut (.*);

  // behavioural reference state
  int m_run, m_slot, m_t, m_n, m_len, m_long, m_alt, m_par, m_pol;
  int m_cs, m_we, m_addr, m_data, m_ce, m_tick;
  int span_cnt, wr_slot;
  int span_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int n_of(input logic [1:0] c);
    return (c == 2'd3) ? 6 : int'(c) + 2;
  endfunction

  always @(posedge clk) begin
    m_tick = tick;
    m_cs = 0; m_we = 0; m_ce = 0;
    if (!rst_n) begin
      m_run = 0; m_slot = 0; m_t = 0; m_n = 2; m_len = 2; m_long = 0;
      m_alt = 0; m_par = 0; m_pol = 0; m_addr = 0; m_data = 0;
      span_cnt = -1; wr_slot = 0; span_q.delete();
    end else if (tick) begin
      bit start;
      start = 0;
      span_cnt++;
      if (m_run == 0) start = 1;
      else if (m_t == m_len - 1) begin
        m_we = 1;
        m_addr = BASE + m_slot;
        m_data = m_long ? int'(adc_data) : int'(adc_data) % (1 << 21);
        if (m_slot == m_n - 1) begin m_ce = 1; start = 1; end
        else begin m_slot++; m_t = 0; m_cs = 1; end
      end else m_t++;
      if (start) begin
        m_par = m_run ? 1 - m_par : 0;
        m_run = 1; m_slot = 0; m_t = 0; m_cs = 1;
        m_n = n_of(cfg_slots); m_len = cfg_long ? 3 : 2;
        m_long = cfg_long; m_alt = cfg_alt;
        if (cfg_chop == 2'b00) m_pol = 0;
        else if (cfg_chop == 2'b01) m_pol = 1;
        else m_pol = 1 - m_pol;
        span_q.push_back(m_n * m_len);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_mux;
      exp_mux = (m_alt && m_par) ? (m_slot ^ 1) : m_slot;
      chk(mux_sel == exp_mux, "R9 mux_sel", mux_sel, exp_mux);
      chk(conv_start == m_cs, "R2 conv_start", conv_start, m_cs);
      chk(ram_we == m_we, "R3 ram_we", ram_we, m_we);
      chk(ram_addr == m_addr, "R3 ram_addr", ram_addr, m_addr);
      chk(ram_wdata == m_data, "R4 ram_wdata", ram_wdata, m_data);
      chk(chop_inv == m_pol, "R5_R6 chop_inv", chop_inv, m_pol);
      chk(ce_go == m_ce, "R7 ce_go", ce_go, m_ce);
      if (!m_tick)
        chk(!(conv_start | ram_we | ce_go), "R11 pulse without tick",
            {conv_start, ram_we, ce_go}, 0);
      if (ram_we) begin
        chk(int'(ram_addr) == BASE + wr_slot, "R3 write order", ram_addr, BASE + wr_slot);
        wr_slot++;
      end
      if (ce_go) begin
        int exp_span;
        exp_span = (span_q.size() > 0) ? span_q.pop_front() : -1;
        chk(span_cnt == exp_span, "R1_R8 cycle tick span", span_cnt, exp_span);
        chk(conv_start == 1'b1, "R7 start with launch", conv_start, 1);
        span_cnt = 0;
        wr_slot = 0;
      end
    end
  end

  always @(negedge clk) adc_data <= 22'($urandom);

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(conv_start == 0 && ram_we == 0 && ce_go == 0, "R10 pulses in reset",
        {conv_start, ram_we, ce_go}, 0);
    chk(mux_sel == 0 && chop_inv == 0, "R10 mux/chop in reset", {mux_sel, chop_inv}, 0);
    chk(ram_addr == 0 && ram_wdata == 0, "R10 ram port in reset", ram_addr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(conv_start == 0, "R10 idle before first tick", conv_start, 0);
    run_ticks(21, 2);
    // R8 mid-cycle change to 6 slots, long filter, toggling chop, alternate order
    cfg_slots = 2'b11; cfg_long = 1'b1; cfg_chop = 2'b10; cfg_alt = 1'b1;
    run_ticks(75, 1);
    cfg_slots = 2'b01; cfg_long = 1'b0; cfg_chop = 2'b01;
    run_ticks(31, 0);
    cfg_slots = 2'b10; cfg_long = 1'b1; cfg_chop = 2'b11; cfg_alt = 1'b0;
    run_ticks(43, 3);
    cfg_slots = 2'b00; cfg_chop = 2'b10; cfg_alt = 1'b1;
    run_ticks(37, 0);
    cfg_chop = 2'b00;
    run_ticks(19, 2);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    finished = 1;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule